// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block multiplies two fixed-point operands each cycle that the input-valid strobe is high. It then adds the product to a running total, or subtracts it from the total. A per-sample load input starts a new sum from the current product, so no separate clear cycle is needed between sums. A per-sample direction input sets the sign of each product's contribution.

Operands are `OP_L + OP_R` bits wide, with `OP_R` fractional bits. A parameter selects one of two formats: two's-complement (signed integer or signed fraction) or unsigned. The accumulator has `OUT_L` integer bits and `2*OP_R` fractional bits, so its binary point lines up with the product's and no shift is needed. `OUT_L` must be larger than `2*OP_L`, which gives the total headroom above the product width. The unit has two register stages: a product register, then the accumulator register.

Top module: `mac_unit`

## Requirements
- R1: While `rst_ni` is low, `acc_o` is zero and `valid_o` is low.
- R2: `valid_o` is high exactly two rising clock edges after a cycle in which `valid_i` was high, and low otherwise.
- R3: With `valid_i=1`, `load_i=0`, `add_i=1`, the accumulator becomes its previous value plus `a_i*b_i`. The result is visible on `acc_o` two clock edges after the inputs.
- R4: With `valid_i=1`, `load_i=0`, `add_i=0`, the accumulator becomes its previous value minus `a_i*b_i`.
- R5: With `valid_i=1`, `load_i=1`, `add_i=1`, the accumulator is replaced by `a_i*b_i` and the old total is discarded.
- R6: With `valid_i=1`, `load_i=1`, `add_i=0`, the accumulator is replaced by `-(a_i*b_i)`.
- R7: In a cycle with `valid_i=0`, the values on `a_i`, `b_i`, `load_i` and `add_i` have no effect, and `acc_o` keeps its value.
- R8: With `SIGNED_MODE=1`, operands are two's complement with the MSB as sign bit, and the product is sign-extended to the accumulator width.
- R9: With `SIGNED_MODE=0`, operands are unsigned and the product is zero-extended to the accumulator width.
- R10: Accumulator arithmetic wraps modulo 2^(`OUT_L`+2*`OP_R`), with no saturation.
- R11: The low `2*OP_R` bits of `acc_o` are fractional. With `OP_R=4`, the operands 0.5 (8'h08) times 0.5 give `acc_o` = 0.25 (17'h00040).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; operands and controls are taken only when high |
| a_i | input | OP_L+OP_R | Operand A |
| b_i | input | OP_L+OP_R | Operand B |
| load_i | input | 1 | 1: start a new sum from this product |
| add_i | input | 1 | 1: add the product, 0: subtract it |
| acc_o | output | OUT_L+2*OP_R | Accumulator value |
| valid_o | output | 1 | High when `acc_o` reflects a new sample |

## Verification
The bench builds two instances that receive the same stimulus. The first is signed with 4.4 operands and a 9-bit integer accumulator part. The second is unsigned with 8-bit integer operands and a 17-bit accumulator. Both accumulators are only one bit wider than the product. This lets a handful of full-scale products wrap the signed total and the unsigned total, so the modulo behaviour is exercised without long runs. The 4.4 format also shows the fractional alignment with exact values. The 8-bit unsigned operands show zero-extension with bytes whose MSB is set.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MAC_SUB = 1'b0,
    MAC_ADD = 1'b1
  } mac_dir_e;

  typedef struct packed {
    logic     vld;
    logic     load;
    mac_dir_e dir;
  } mac_ctrl_t;
endpackage

// File: rtl/mac_prod_stage.sv
module mac_prod_stage
  import mac_pkg::*;
#(
  parameter int OP_W        = 8,
  parameter int ACC_W       = 17,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             load_i,
  input  logic             add_i,
  output logic [ACC_W-1:0] prod_o,
  output mac_ctrl_t        ctrl_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic [ACC_W-1:0] prod_ext;

  generate
    if (SIGNED_MODE) begin : g_signed
      logic signed [PROD_W-1:0] p_s;
      assign p_s      = $signed(a_i) * $signed(b_i);
      assign prod_ext = {{EXT_W{p_s[PROD_W-1]}}, p_s};
    end else begin : g_unsigned
      logic [PROD_W-1:0] p_u;
      assign p_u      = a_i * b_i;
      assign prod_ext = {{EXT_W{1'b0}}, p_u};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      ctrl_o <= '{vld: 1'b0, load: 1'b0, dir: MAC_ADD};
    end else begin
      ctrl_o.vld <= valid_i;
      if (valid_i) begin
        prod_o      <= prod_ext;
        ctrl_o.load <= load_i;
        ctrl_o.dir  <= add_i ? MAC_ADD : MAC_SUB;
      end
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int ACC_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] prod_i,
  input  mac_ctrl_t        ctrl_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] term;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] acc_nxt;

  always_comb begin
    term    = (ctrl_i.dir == MAC_ADD) ? prod_i : (~prod_i + 1'b1);
    base    = ctrl_i.load ? '0 : acc_o;
    acc_nxt = base + term;  // wraps modulo 2^ACC_W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ctrl_i.vld;
      if (ctrl_i.vld) acc_o <= acc_nxt;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_L        = 4,
  parameter int OP_R        = 4,
  parameter int OUT_L       = 9,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int OP_W       = OP_L + OP_R,
  localparam int ACC_W      = OUT_L + 2 * OP_R
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             load_i,
  input  logic             add_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] prod_q;
  mac_ctrl_t        ctrl_q;

  mac_prod_stage #(
    .OP_W       (OP_W),
    .ACC_W      (ACC_W),
    .SIGNED_MODE(SIGNED_MODE)
  ) u_prod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .load_i (load_i),
    .add_i  (add_i),
    .prod_o (prod_q),
    .ctrl_o (ctrl_q)
  );

  mac_acc_stage #(
    .ACC_W(ACC_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prod_i (prod_q),
    .ctrl_i (ctrl_q),
    .acc_o  (acc_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W        = 8,
  parameter int ACC_W       = 17,
  parameter bit SIGNED_MODE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic             load_i,
  input logic             add_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             valid_o
);
  localparam int PROD_W = 2 * OP_W;

  logic [1:0]       cyc_q;
  logic [ACC_W-1:0] prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  generate
    if (SIGNED_MODE) begin : g_s
      logic signed [PROD_W-1:0] p;
      assign p        = $signed(a_i) * $signed(b_i);
      assign prod_ext = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    end else begin : g_u
      logic [PROD_W-1:0] p;
      assign p        = a_i * b_i;
      assign prod_ext = {{(ACC_W-PROD_W){1'b0}}, p};
    end
  endgenerate

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (acc_o == '0 && !valid_o));

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (valid_o == $past(valid_i, 2)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !valid_o) |-> $stable(acc_o));

  // R5 R6
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && valid_o && $past(load_i, 2)) |->
      (acc_o == ($past(add_i, 2) ? $past(prod_ext, 2) : (~$past(prod_ext, 2) + 1'b1))));

  // R3 R4 R10
  accum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && valid_o && !$past(load_i, 2)) |->
      (acc_o == ($past(add_i, 2) ? ($past(acc_o) + $past(prod_ext, 2))
                                 : ($past(acc_o) - $past(prod_ext, 2)))));
endmodule

bind mac_unit mac_unit_chk #(
  .OP_W       (OP_W),
  .ACC_W      (ACC_W),
  .SIGNED_MODE(SIGNED_MODE)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .load_i (load_i),
  .add_i  (add_i),
  .acc_o  (acc_o),
  .valid_o(valid_o)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, ld = 1'b0, ad = 1'b1;
  logic [7:0] a = '0, b = '0;
  logic [16:0] acc_s, acc_u;
  logic vo_s, vo_u;
  logic [16:0] m_s, m_u;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mac_unit #(.OP_L(4), .OP_R(4), .OUT_L(9), .SIGNED_MODE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .load_i(ld), .add_i(ad), .acc_o(acc_s), .valid_o(vo_s));

  mac_unit #(.OP_L(8), .OP_R(0), .OUT_L(17), .SIGNED_MODE(1'b0)) dut_u_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .load_i(ld), .add_i(ad), .acc_o(acc_u), .valid_o(vo_u));

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one valid sample, then check both units two edges later
  task automatic step(input string req, input logic [7:0] ai, input logic [7:0] bi,
                      input logic li, input logic di);
    int ps, pu;
    logic [16:0] ts, tu;
    @(negedge clk);
    a = ai; b = bi; ld = li; ad = di; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; a = ~ai; b = ~bi; ld = ~li; ad = ~di;
    @(negedge clk);
    ps = int'($signed(ai)) * int'($signed(bi));
    pu = int'(ai) * int'(bi);
    ts = di ? ps[16:0] : -ps[16:0];
    tu = di ? pu[16:0] : -pu[16:0];
    m_s = li ? ts : m_s + ts;
    m_u = li ? tu : m_u + tu;
    chk({req, " signed"}, acc_s, m_s);
    chk({req, " unsigned"}, acc_u, m_u);
    chk({req, " R2 valid_o"}, {16'h0, vo_s & vo_u}, 17'h1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 acc", acc_s | acc_u, '0);
    chk("R1 valid", {16'h0, vo_s | vo_u}, '0);
    m_s = '0; m_u = '0;
  endtask

  task automatic t_fraction;
    step("R5 R11", 8'h08, 8'h08, 1'b1, 1'b1);
    chk("R11 0.5*0.5", acc_s, 17'h00040);
    step("R3 R11", 8'h18, 8'h08, 1'b0, 1'b1);  // + 1.5*0.5
    chk("R11 sum", acc_s, 17'h00100);
  endtask

  task automatic t_signs;
    step("R8 R5", 8'hF0, 8'h20, 1'b1, 1'b1);   // -1.0 * 2.0
    chk("R8 neg product", acc_s, 17'h1FE00);
    chk("R9 zero extend", acc_u, 17'h01E00);
    step("R4", 8'hF0, 8'hF0, 1'b0, 1'b0);
    step("R3", 8'h7F, 8'h81, 1'b0, 1'b1);
    step("R6", 8'h05, 8'h03, 1'b1, 1'b0);
    chk("R6 neg load", acc_s, 17'h1FFF1);
    step("R4 sub", 8'hFF, 8'h02, 1'b0, 1'b0);
  endtask

  task automatic t_ignore;
    logic [16:0] hs, hu;
    hs = acc_s; hu = acc_u;
    @(negedge clk);
    a = 8'h55; b = 8'hAA; ld = 1'b1; ad = 1'b0; vld = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 signed hold", acc_s, hs);
    chk("R7 unsigned hold", acc_u, hu);
    chk("R7 R2 no valid", {16'h0, vo_s | vo_u}, '0);
  endtask

  task automatic t_wrap;
    step("R5 R10", 8'h80, 8'h80, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) step("R10", 8'h80, 8'h80, 1'b0, 1'b1);
    chk("R10 signed wrap", acc_s, 17'h00000);
    step("R5 R10 u", 8'hFF, 8'hFF, 1'b1, 1'b1);
    step("R10 u", 8'hFF, 8'hFF, 1'b0, 1'b1);
    step("R10 u", 8'hFF, 8'hFF, 1'b0, 1'b1);
    chk("R10 unsigned wrap", acc_u, 17'(195075));
  endtask

  task automatic t_back2back;
    @(negedge clk);
    a = 8'h03; b = 8'h04; ld = 1'b1; ad = 1'b1; vld = 1'b1;
    @(negedge clk);
    a = 8'h02; b = 8'h05; ld = 1'b0; ad = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    chk("R3 back-to-back", acc_u, 17'd22);
    chk("R2 back-to-back", {16'h0, vo_u}, 17'h1);
    @(negedge clk);
    chk("R2 drop", {16'h0, vo_u}, 17'h0);
    m_s = acc_s; m_u = acc_u;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fraction();
    t_signs();
    t_ignore();
    t_wrap();
    t_back2back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule